// File: doc/BRIEF.md
# Banked Display-Memory Window Translator

This block sits between a host bus decoder and a video-memory controller. A host access that falls inside the display-memory aperture is turned into a linear video-memory address. The address is formed by adding one of two page offsets, at 4 KB granularity, to the access's position inside the aperture. The aperture can be the classic 128 KB legacy window at A0000h, or a linear region of 256 KB, 512 KB or 1 MB starting at zero.

Software programs three values through a small write port: the offset of page register A, the offset of page register B, and a mode byte. The mode byte chooses how the two offsets are used. They can split traffic by access direction (reads through A, writes through B). They can split the window by position, with B covering the first 32 KB and A the rest. Or A alone can cover the whole window. The mode byte also sets the offset width, the aperture and the installed memory size, and sums wrap modulo that size. Each translated request shows up on the outputs one clock after it is presented.

Top module: `win_xlate`

## Requirements
- R1: After reset, `hit` is low, both page offsets are zero and the mode byte is zero (legacy aperture, 256 KB installed, A only, 7-bit offsets). A read at A1234h therefore translates to 01234h.
- R2: The 2-bit aperture field (mode bits 3:2) selects the range that raises `hit`: 0 gives A0000h–BFFFFh, 1 gives 0–3FFFFh, 2 gives 0–7FFFFh and 3 gives 0–FFFFFh. The window position is the host address minus the aperture base. A request outside the range leaves `hit` low.
- R3: The translated address is the window position plus the selected offset times 4096. Its low 12 bits always equal those of the host address.
- R4: With mode bit 6 clear, only the low 7 bits of the selected offset take part in the sum. With bit 6 set, all 8 bits do.
- R5: With mode bit 0 (direction split) set, reads (`req_write`=0) use offset A and writes use offset B, wherever they fall in the window.
- R6: With mode bit 0 clear and mode bit 1 (second page enable) set, window positions 0–7FFFh use offset B and all higher positions use offset A.
- R7: With mode bits 0 and 1 both clear, offset A serves the whole window.
- R8: The sum wraps modulo the installed memory size, set by mode bits 5:4: 0 and 1 mean 256 KB, 2 means 512 KB, 3 means 1 MB.
- R9: `hit` and `mem_addr` are registered. They reflect the request presented at the previous clock edge, and `hit` is low one cycle after a cycle with `req_valid` low.
- R10: A write with `cfg_we` high stores `cfg_wdata` into offset A when `cfg_sel`=0, into offset B when `cfg_sel`=1, and into the mode byte when `cfg_sel`=2. A write with `cfg_sel`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 offset A, 1 offset B, 2 mode, 3 none |
| cfg_wdata | input | OFS_W (8) | Configuration write data |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | Host request is a write |
| req_addr | input | HOST_AW (20) | Host byte address |
| hit | output | 1 | Previous request fell inside the aperture |
| mem_addr | output | MEM_AW (20) | Translated video-memory byte address |

## Verification
Each configuration is swept over every 4 KB page of the 1 MB host space. Each page is probed at its first byte, at its 0x7FF byte and at its last byte, with both reads and writes. This covers the aperture edges, the 32 KB half boundary at A7FFFh/A8000h and the low-12-bit pass-through. The configurations are chosen so that offsets A and B differ, which shows which bank served each access. The direction-split sweep separates R5 from the positional split of R6. An offset with bit 7 set is run with both offset widths to expose R4. Large offsets on small installed sizes force the wrap of R8. A mode write aimed at the unused select must leave the previous sweep's results unchanged.

// File: rtl/win_pkg.sv
package win_pkg;

    // configuration write targets
    typedef enum logic [1:0] {
        SEL_OFS_A = 2'd0,
        SEL_OFS_B = 2'd1,
        SEL_MODE  = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;

    // mode byte, bit 0 at the bottom
    typedef struct packed {
        logic       wide_ofs;   // bit 6: full-width offsets
        logic [1:0] mem_size;   // bits 5:4: installed memory size code
        logic [1:0] apt_map;    // bits 3:2: aperture select
        logic       b_enable;   // bit 1: second page register in use
        logic       dir_split;  // bit 0: reads via A, writes via B
    } win_mode_t;

    localparam int unsigned MODE_W       = 7;
    localparam int unsigned LEGACY_BASE  = 32'h000A_0000;
    localparam int unsigned APT_LOG2_MIN = 17;   // legacy window = 128 KB
    localparam int unsigned HALF_LOG2    = 15;   // 32 KB window halves

endpackage

// File: rtl/win_cfg_regs.sv
module win_cfg_regs
    import win_pkg::*;
#(
    parameter int unsigned OFS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [OFS_W-1:0] cfg_wdata,
    output logic [OFS_W-1:0] ofs_a,
    output logic [OFS_W-1:0] ofs_b,
    output win_mode_t        mode
);

    typedef struct packed {
        logic [OFS_W-1:0] ofs_a;
        logic [OFS_W-1:0] ofs_b;
        win_mode_t        mode;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (cfg_we) begin
            unique case (cfg_sel_e'(cfg_sel))
                SEL_OFS_A: regs_d.ofs_a = cfg_wdata;
                SEL_OFS_B: regs_d.ofs_b = cfg_wdata;
                SEL_MODE:  regs_d.mode  = win_mode_t'(cfg_wdata[MODE_W-1:0]);
                SEL_NONE:  regs_d       = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign ofs_a = regs_q.ofs_a;
    assign ofs_b = regs_q.ofs_b;
    assign mode  = regs_q.mode;

endmodule

// File: rtl/win_decode.sv
module win_decode
    import win_pkg::*;
#(
    parameter int unsigned HOST_AW = 20,
    parameter int unsigned OFS_W   = 8
) (
    input  logic [HOST_AW-1:0] req_addr,
    input  logic               req_write,
    input  win_mode_t          mode,
    input  logic [OFS_W-1:0]   ofs_a,
    input  logic [OFS_W-1:0]   ofs_b,
    output logic               in_apt,
    output logic [HOST_AW-1:0] win_pos,
    output logic [OFS_W-1:0]   ofs_sel
);

    localparam int unsigned XW = HOST_AW + 1;
    localparam logic [XW-1:0] BASE_LEGACY = XW'(LEGACY_BASE);

    logic [XW-1:0]      base;
    logic [XW-1:0]      span;
    logic [XW-1:0]      addr_x;
    logic               above_base;
    logic               low_half;
    logic               use_b;
    logic [OFS_W-1:0]   ofs_raw;
    logic [OFS_W-1:0]   ofs_mask;

    always_comb begin
        base   = (mode.apt_map == 2'd0) ? BASE_LEGACY : '0;
        span   = XW'(1) << (APT_LOG2_MIN + 32'(mode.apt_map));
        addr_x = {1'b0, req_addr};
        above_base = (addr_x >= base);
        win_pos    = req_addr - base[HOST_AW-1:0];
        in_apt     = above_base && ({1'b0, win_pos} < span);
        low_half   = (win_pos >> HALF_LOG2) == '0;
    end

    always_comb begin
        if (mode.dir_split)      use_b = req_write;
        else if (mode.b_enable)  use_b = low_half;
        else                     use_b = 1'b0;
        ofs_raw  = use_b ? ofs_b : ofs_a;
        ofs_mask = mode.wide_ofs ? '1 : {1'b0, {(OFS_W-1){1'b1}}};
        ofs_sel  = ofs_raw & ofs_mask;
    end

endmodule

// File: rtl/win_addr_calc.sv
module win_addr_calc
    import win_pkg::*;
#(
    parameter int unsigned HOST_AW = 20,
    parameter int unsigned MEM_AW  = 20,
    parameter int unsigned OFS_W   = 8,
    parameter int unsigned PAGE_W  = 12
) (
    input  logic [HOST_AW-1:0] win_pos,
    input  logic [OFS_W-1:0]   ofs_sel,
    input  logic [1:0]         mem_size,
    output logic [MEM_AW-1:0]  phys
);

    logic [MEM_AW-1:0] sum;
    logic [MEM_AW-1:0] wrap_mask;

    always_comb begin
        sum = MEM_AW'(win_pos) + (MEM_AW'(ofs_sel) << PAGE_W);
        unique case (mem_size)
            2'd0, 2'd1: wrap_mask = {MEM_AW{1'b1}} >> 2;
            2'd2:       wrap_mask = {MEM_AW{1'b1}} >> 1;
            default:    wrap_mask = {MEM_AW{1'b1}};
        endcase
        phys = sum & wrap_mask;
    end

endmodule

// File: rtl/win_xlate_chk.sv
module win_xlate_chk
    import win_pkg::*;
#(
    parameter int unsigned HOST_AW = 20,
    parameter int unsigned MEM_AW  = 20,
    parameter int unsigned OFS_W   = 8,
    parameter int unsigned PAGE_W  = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic [1:0]         cfg_sel,
    input logic               req_valid,
    input logic [HOST_AW-1:0] req_addr,
    input logic               hit,
    input logic [MEM_AW-1:0]  mem_addr,
    input win_mode_t          mode,
    input logic [OFS_W-1:0]   ofs_a,
    input logic [OFS_W-1:0]   ofs_b
);

    localparam logic [HOST_AW:0] LEG_LO = (HOST_AW+1)'(LEGACY_BASE);
    localparam logic [HOST_AW:0] LEG_HI = (HOST_AW+1)'(LEGACY_BASE + (32'd1 << APT_LOG2_MIN));

    function automatic logic [MEM_AW:0] size_of(input logic [1:0] code);
        if (code == 2'd3)      return (MEM_AW+1)'(1) << MEM_AW;
        else if (code == 2'd2) return (MEM_AW+1)'(1) << (MEM_AW - 1);
        else                   return (MEM_AW+1)'(1) << (MEM_AW - 2);
    endfunction

    AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !hit); // R9

    AST_LEGACY_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && mode.apt_map == 2'd0 &&
        ({1'b0, req_addr} < LEG_LO || {1'b0, req_addr} >= LEG_HI) |=> !hit); // R2

    AST_FULL_MAP_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && mode.apt_map == 2'd3 |=> hit); // R2

    AST_PAGE_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> mem_addr[PAGE_W-1:0] == $past(req_addr[PAGE_W-1:0])); // R3

    AST_WRAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> {1'b0, mem_addr} < size_of($past(mode.mem_size))); // R8

    AST_NULL_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_sel == 2'd3 |=> $stable(ofs_a) && $stable(ofs_b) && $stable(mode)); // R10

endmodule

bind win_xlate win_xlate_chk #(
    .HOST_AW(HOST_AW), .MEM_AW(MEM_AW), .OFS_W(OFS_W), .PAGE_W(PAGE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .req_valid(req_valid), .req_addr(req_addr), .hit(hit), .mem_addr(mem_addr),
    .mode(mode), .ofs_a(ofs_a), .ofs_b(ofs_b)
);

// File: rtl/win_xlate.sv
module win_xlate
    import win_pkg::*;
#(
    parameter int unsigned HOST_AW = 20,
    parameter int unsigned MEM_AW  = 20,
    parameter int unsigned OFS_W   = 8,
    parameter int unsigned PAGE_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [OFS_W-1:0]   cfg_wdata,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [HOST_AW-1:0] req_addr,
    output logic               hit,
    output logic [MEM_AW-1:0]  mem_addr
);

    typedef struct packed {
        logic              hit;
        logic [MEM_AW-1:0] addr;
    } out_t;

    logic [OFS_W-1:0]   ofs_a;
    logic [OFS_W-1:0]   ofs_b;
    win_mode_t          mode;
    logic               in_apt;
    logic [HOST_AW-1:0] win_pos;
    logic [OFS_W-1:0]   ofs_sel;
    logic [MEM_AW-1:0]  phys;
    out_t               out_d, out_q;

    win_cfg_regs #(.OFS_W(OFS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ofs_a(ofs_a), .ofs_b(ofs_b), .mode(mode)
    );

    win_decode #(.HOST_AW(HOST_AW), .OFS_W(OFS_W)) u_dec (
        .req_addr(req_addr), .req_write(req_write), .mode(mode),
        .ofs_a(ofs_a), .ofs_b(ofs_b), .in_apt(in_apt),
        .win_pos(win_pos), .ofs_sel(ofs_sel)
    );

    win_addr_calc #(.HOST_AW(HOST_AW), .MEM_AW(MEM_AW), .OFS_W(OFS_W), .PAGE_W(PAGE_W)) u_calc (
        .win_pos(win_pos), .ofs_sel(ofs_sel), .mem_size(mode.mem_size), .phys(phys)
    );

    always_comb begin
        out_d.hit  = req_valid && in_apt;
        out_d.addr = out_d.hit ? phys : out_q.addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign hit      = out_q.hit;
    assign mem_addr = out_q.addr;

endmodule

// File: tb/win_xlate_bench.sv
module win_xlate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [7:0]  cfg_wdata = 8'd0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = 20'd0;
    logic        hit;
    logic [19:0] mem_addr;

    int compared = 0;
    int mismatched = 0;
    int m_a = 0, m_b = 0, m_mode = 0;

    always #10 clk = ~clk;

    win_xlate u_win_xlate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .hit(hit), .mem_addr(mem_addr)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        #4000000;
        mismatched++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        summary();
        $finish;
    end

    // expected {hit, addr} from the requirements
    function automatic int model_hit(input int a);
        int map = (m_mode >> 2) & 3;
        int base = (map == 0) ? 'hA0000 : 0;
        int span = 1 << (17 + map);
        return (a >= base && (a - base) < span) ? 1 : 0;
    endfunction

    function automatic int model_addr(input int a, input int wr);
        int map   = (m_mode >> 2) & 3;
        int size  = (m_mode >> 4) & 3;
        int base  = (map == 0) ? 'hA0000 : 0;
        int w     = a - base;
        int useb;
        int ofs;
        int msz;
        if (m_mode & 1)      useb = wr;
        else if (m_mode & 2) useb = (w < 'h8000) ? 1 : 0;
        else                 useb = 0;
        ofs = useb ? m_b : m_a;
        if ((m_mode & 'h40) == 0) ofs = ofs % 128;
        msz = (size == 3) ? 'h100000 : (size == 2) ? 'h80000 : 'h40000;
        return (w + ofs * 4096) % msz;
    endfunction

    task automatic cfg_write(input int sel, input int data);
        cfg_we = 1'b1; cfg_sel = sel[1:0]; cfg_wdata = data[7:0];
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 0) m_a = data;
        else if (sel == 1) m_b = data;
        else if (sel == 2) m_mode = data & 'h7F;
    endtask

    task automatic access(input int a, input int wr, input string tag);
        int eh, ea;
        req_valid = 1'b1; req_write = wr[0]; req_addr = a[19:0];
        @(negedge clk);
        eh = model_hit(a);
        ea = model_addr(a, wr);
        compared++;
        if (int'(hit) != eh) begin
            mismatched++;
            $display("FAIL %s hit addr=%h wr=%0d: actual %0d expected %0d", tag, a, wr, hit, eh);
        end else if (eh == 1 && int'(mem_addr) != ea) begin
            mismatched++;
            $display("FAIL %s mem_addr addr=%h wr=%0d: actual %h expected %h", tag, a, wr, mem_addr, ea);
        end
    endtask

    task automatic idle_check();
        req_valid = 1'b0;
        @(negedge clk);
        compared++;
        if (hit !== 1'b0) begin
            mismatched++;
            $display("FAIL R9 idle: actual hit %b expected 0", hit);
        end
    endtask

    task automatic sweep(input string tag);
        for (int page = 0; page < 256; page++) begin
            for (int k = 0; k < 3; k++) begin
                for (int wr = 0; wr < 2; wr++) begin
                    int low = (k == 0) ? 0 : (k == 1) ? 'h7FF : 'hFFF;
                    access(page * 4096 + low, wr, tag);
                end
            end
        end
        idle_check();
    endtask

    task automatic setup(input int a, input int b, input int mode);
        cfg_write(0, a);
        cfg_write(1, b);
        cfg_write(2, mode);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        compared++;
        if (hit !== 1'b0) begin
            mismatched++;
            $display("FAIL R1 reset hit: actual %b expected 0", hit);
        end
        access('hA1234, 0, "R1");
        sweep("R1");

        setup('h13, 'h25, 'h30); sweep("R7");
        setup('h13, 'h25, 'h32); sweep("R6");
        setup('h13, 'h25, 'h33); sweep("R5");
        setup('h93, 'hC5, 'h32); sweep("R4");
        setup('h93, 'hC5, 'h72); sweep("R3");
        setup('h3A, 'h01, 'h66); sweep("R2");
        setup('h9C, 'h41, 'h79); sweep("R2");
        setup('hFF, 'h80, 'h4E); sweep("R8");
        setup('hF0, 'h87, 'h2E); sweep("R8");
        // R10: unused select must not disturb any register
        cfg_write(3, 'h00);
        sweep("R10");
        cfg_write(3, 'hFF);
        sweep("R10");

        summary();
        $finish;
    end

endmodule